// File: doc/BRIEF.md
# Indirect-Access Multiply-Accumulate and Divide Unit

This block is a math coprocessor for a small processor. It has three 64-bit operand registers, named A, B and C, and a bank of 40 byte-wide scratch registers. None of them is mapped directly onto the processor bus. The processor sets an index register first, then reads or writes bytes through a single data window. The index steps forward by one after every data access. A 64-bit operand can therefore be streamed in or out with eight consecutive accesses, most significant byte first.

Two control registers start the work. The multiply control forms C = A*B or C = A*B + C. It can run in 32-bit mode, where only the low halves of A and B are used and C stays 64 bits wide, or in 64-bit mode, with signed or unsigned operands. The divide control divides C by A. The quotient goes to A and the remainder to B, with signed or unsigned operands and optional rounding. Both operations are iterative. The start bit reads back as 1 until the result has been written.

A state machine sequences each operation through four states. ST_IDLE goes to ST_MUL_RUN on a multiply start, or to ST_DIV_RUN on a divide start. ST_MUL_RUN goes to ST_WRITE_BACK once no multiplier bits remain. ST_DIV_RUN goes to ST_WRITE_BACK after its last quotient step, or after one cycle if the divisor is zero. ST_WRITE_BACK loads the results into the operand bytes and always returns to ST_IDLE.

Top module: `xmath_unit`

## Requirements
- R1: After reset, every byte, the index and both control registers read as zero.
- R2: Select codes: 0 = index, 1 = data window, 2 = multiply control, 3 = divide control. Each read or write of the data window advances the index by one, and the index wraps from 0x3F to 0x00. Reading the index or the control registers does not advance it.
- R3: Byte map: A is at 0x00-0x07, B at 0x08-0x0F and C at 0x10-0x17. In each operand the most significant byte sits at the lowest address.
- R4: Bytes 0x18-0x3F are plain storage. They keep what was written and can be written at any time.
- R5: Multiply control bits: 7 = start, 6 = accumulate, 4 = 64-bit, 3 = signed. A signed 32-bit accumulate sign-extends the low halves of A and B and ignores their upper halves. For example, 0x1234 * 0x5678 + (-0x2000) gives C = 0x000000000625E060.
- R6: An unsigned 32-bit multiply zero-extends the low halves of A and B.
- R7: A 64-bit multiply or accumulate leaves in C the product (plus C) truncated to 64 bits.
- R8: With bit 6 clear, the earlier contents of C have no effect. A multiply never changes A or B.
- R9: Bit 7 of a control register reads 1 from the cycle after a start until the results are written, then reads 0. The other stored bits read back unchanged.
- R10: Divide control bits: 7 = start, 6 = round, 3 = signed. An unsigned divide puts C/A in A and C mod A in B, and leaves C unchanged.
- R11: A signed divide truncates the quotient toward zero. The remainder takes the sign of C.
- R12: With rounding, the magnitude of the quotient grows by one when twice the remainder magnitude is at least the divisor magnitude. B then holds C - A*Q, modulo 2^64.
- R13: Dividing by zero writes all ones to A and copies C into B, three cycles after the start.
- R14: Writes to bytes 0x00-0x17 are ignored from the cycle after a start through the write-back cycle. They are accepted again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe; advances the index when the data window is selected |
| bus_sel | input | 2 | Register select (0 index, 1 data, 2 multiply control, 3 divide control) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |

## Verification
Two things can land in the same cycle: a processor write to an operand byte and the write-back of a result. The bench provokes this with a multiply whose B is zero, which makes the busy window exactly two cycles long. It then writes three consecutive bytes of A in the three cycles after the start. The first two writes, including the one that coincides with write-back, must leave A unchanged. The third must land, and C must still receive its result.

// File: rtl/xmu_pkg.sv
package xmu_pkg;
    typedef enum logic [1:0] {
        SEL_INDEX  = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_MACCTL = 2'd2,
        SEL_DIVCTL = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_MUL_RUN    = 2'd1,
        ST_DIV_RUN    = 2'd2,
        ST_WRITE_BACK = 2'd3
    } state_e;

    // control word bit positions
    localparam int BIT_GO   = 7;
    localparam int BIT_MODE = 6;   // accumulate (multiply) or round (divide)
    localparam int BIT_WIDE = 4;
    localparam int BIT_SGN  = 3;
endpackage

// File: rtl/xmu_regfile.sv
module xmu_regfile #(
    parameter  int OP_BYTES = 8,
    parameter  int GP_BYTES = 40,
    localparam int OP_W     = 8 * OP_BYTES,
    localparam int N_BYTES  = 3 * OP_BYTES + GP_BYTES,
    localparam int IDX_W    = $clog2(N_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             acc_wr,
    input  logic             acc_rd,
    input  logic [7:0]       acc_wdata,
    input  logic             lock,
    input  logic             ld_ab,
    input  logic             ld_c,
    input  logic [OP_W-1:0]  res_a,
    input  logic [OP_W-1:0]  res_b,
    input  logic [OP_W-1:0]  res_c,
    output logic [7:0]       rd_byte,
    output logic [IDX_W-1:0] idx,
    output logic [OP_W-1:0]  op_a,
    output logic [OP_W-1:0]  op_b,
    output logic [OP_W-1:0]  op_c
);
    localparam int MEM_D = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST     = IDX_W'(N_BYTES - 1);
    localparam logic [IDX_W-1:0] OPER_END = IDX_W'(3 * OP_BYTES);

    logic [7:0]       mem [MEM_D];
    logic [IDX_W-1:0] idx_q;
    logic             wr_ok;

    assign wr_ok   = acc_wr && (!lock || (idx_q >= OPER_END));
    assign idx     = idx_q;
    assign rd_byte = mem[idx_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_wr) begin
            idx_q <= idx_wdata;
        end else if (acc_wr || acc_rd) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_D; i++) mem[i] <= '0;
        end else begin
            if (wr_ok) mem[idx_q] <= acc_wdata;
            for (int g = 0; g < OP_BYTES; g++) begin
                if (ld_ab) begin
                    mem[g]            <= res_a[OP_W-1-8*g -: 8];
                    mem[OP_BYTES + g] <= res_b[OP_W-1-8*g -: 8];
                end
                if (ld_c) mem[2*OP_BYTES + g] <= res_c[OP_W-1-8*g -: 8];
            end
        end
    end

    for (genvar g = 0; g < OP_BYTES; g++) begin : g_view
        assign op_a[OP_W-1-8*g -: 8] = mem[g];
        assign op_b[OP_W-1-8*g -: 8] = mem[OP_BYTES + g];
        assign op_c[OP_W-1-8*g -: 8] = mem[2*OP_BYTES + g];
    end
endmodule

// File: rtl/xmu_mul.sv
module xmu_mul #(
    parameter int OP_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            wide,
    input  logic            sgn,
    input  logic            acc,
    input  logic [OP_W-1:0] a,
    input  logic [OP_W-1:0] b,
    input  logic [OP_W-1:0] c,
    output logic            done,
    output logic [OP_W-1:0] prod
);
    localparam int HALF = OP_W / 2;

    logic            running;
    logic [OP_W-1:0] mcand_q, mplier_q, prod_q;

    function automatic logic [OP_W-1:0] widen(input logic [OP_W-1:0] v,
                                              input logic w, input logic s);
        if (w) return v;
        return s ? {{HALF{v[HALF-1]}}, v[HALF-1:0]} : {{HALF{1'b0}}, v[HALF-1:0]};
    endfunction

    // last step: no multiplier bits remain above the one being consumed
    assign done = running && (mplier_q[OP_W-1:1] == '0);
    assign prod = prod_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running  <= 1'b0;
            mcand_q  <= '0;
            mplier_q <= '0;
            prod_q   <= '0;
        end else if (start) begin
            running  <= 1'b1;
            mcand_q  <= widen(a, wide, sgn);
            mplier_q <= widen(b, wide, sgn);
            prod_q   <= acc ? c : '0;
        end else if (running) begin
            if (mplier_q[0]) prod_q <= prod_q + mcand_q;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
            if (done) running <= 1'b0;
        end
    end
endmodule

// File: rtl/xmu_div.sv
module xmu_div #(
    parameter int OP_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            sgn,
    input  logic            rnd,
    input  logic [OP_W-1:0] dvd,
    input  logic [OP_W-1:0] dvs,
    output logic            done,
    output logic [OP_W-1:0] quo,
    output logic [OP_W-1:0] rem
);
    localparam int CW = $clog2(OP_W);
    localparam logic [CW-1:0] LAST_STEP = CW'(OP_W - 1);

    logic            running, zero_q, negq_q, negr_q, rnd_q;
    logic [OP_W-1:0] dvs_q, raw_q, work_q, part_q;
    logic [CW-1:0]   cnt_q;
    logic [OP_W:0]   trial;
    logic            fits, rnd_up;
    logic [OP_W-1:0] qfin, rfin;

    function automatic logic [OP_W-1:0] mag(input logic [OP_W-1:0] v, input logic s);
        return (s && v[OP_W-1]) ? (~v + 1'b1) : v;
    endfunction

    assign trial = {part_q, work_q[OP_W-1]} - {1'b0, dvs_q};
    assign fits  = !trial[OP_W];
    assign done  = running && (zero_q || cnt_q == LAST_STEP);

    // result fix-up, valid once the last step has been taken
    assign rnd_up = rnd_q && !zero_q && ({part_q, 1'b0} >= {1'b0, dvs_q});
    assign qfin   = work_q + OP_W'(rnd_up);
    assign rfin   = rnd_up ? (dvs_q - part_q) : part_q;
    assign quo    = zero_q ? '1 : (negq_q ? (~qfin + 1'b1) : qfin);
    assign rem    = zero_q ? raw_q : ((negr_q ^ rnd_up) ? (~rfin + 1'b1) : rfin);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            zero_q  <= 1'b0;
            negq_q  <= 1'b0;
            negr_q  <= 1'b0;
            rnd_q   <= 1'b0;
            dvs_q   <= '0;
            raw_q   <= '0;
            work_q  <= '0;
            part_q  <= '0;
            cnt_q   <= '0;
        end else if (start) begin
            running <= 1'b1;
            zero_q  <= (dvs == '0);
            negq_q  <= sgn && (dvd[OP_W-1] ^ dvs[OP_W-1]);
            negr_q  <= sgn && dvd[OP_W-1];
            rnd_q   <= rnd;
            dvs_q   <= mag(dvs, sgn);
            raw_q   <= dvd;
            work_q  <= mag(dvd, sgn);
            part_q  <= '0;
            cnt_q   <= '0;
        end else if (running) begin
            if (!zero_q) begin
                part_q <= fits ? trial[OP_W-1:0] : {part_q[OP_W-2:0], work_q[OP_W-1]};
                work_q <= {work_q[OP_W-2:0], fits};
                cnt_q  <= cnt_q + 1'b1;
            end
            if (done) running <= 1'b0;
        end
    end
endmodule

// File: rtl/xmu_ctrl.sv
module xmu_ctrl
    import xmu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_mac,
    input  logic   wr_div,
    input  logic   go,
    input  logic   mode,
    input  logic   wide,
    input  logic   sgn,
    input  logic   mul_done,
    input  logic   div_done,
    output logic   mul_start,
    output logic   div_start,
    output logic   lock,
    output logic   ld_ab,
    output logic   ld_c,
    output logic   mac_active,
    output logic   div_active,
    output logic   mac_acc,
    output logic   mac_wide,
    output logic   mac_sgn,
    output logic   div_rnd,
    output logic   div_sgn,
    output state_e st
);
    state_e st_q, st_d;
    logic   op_mac_q;
    logic   idle;

    assign idle      = (st_q == ST_IDLE);
    assign mul_start = idle && wr_mac && go;
    assign div_start = idle && wr_div && go;
    assign st        = st_q;

    // state register and per-operation configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            op_mac_q <= 1'b0;
            mac_acc  <= 1'b0;
            mac_wide <= 1'b0;
            mac_sgn  <= 1'b0;
            div_rnd  <= 1'b0;
            div_sgn  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (idle && wr_mac) begin
                mac_acc  <= mode;
                mac_wide <= wide;
                mac_sgn  <= sgn;
            end
            if (idle && wr_div) begin
                div_rnd <= mode;
                div_sgn <= sgn;
            end
            if (mul_start) op_mac_q <= 1'b1;
            else if (div_start) op_mac_q <= 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (mul_start)      st_d = ST_MUL_RUN;
                else if (div_start) st_d = ST_DIV_RUN;
            end
            ST_MUL_RUN:    if (mul_done) st_d = ST_WRITE_BACK;
            ST_DIV_RUN:    if (div_done) st_d = ST_WRITE_BACK;
            ST_WRITE_BACK: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        lock       = 1'b1;
        ld_ab      = 1'b0;
        ld_c       = 1'b0;
        mac_active = 1'b0;
        div_active = 1'b0;
        unique case (st_q)
            ST_IDLE: lock = 1'b0;
            ST_MUL_RUN: mac_active = 1'b1;
            ST_DIV_RUN: div_active = 1'b1;
            ST_WRITE_BACK: begin
                mac_active = op_mac_q;
                div_active = !op_mac_q;
                ld_c       = op_mac_q;
                ld_ab      = !op_mac_q;
            end
        endcase
    end
endmodule

// File: rtl/xmath_unit.sv
module xmath_unit #(
    parameter int OP_BYTES = 8,
    parameter int GP_BYTES = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    import xmu_pkg::*;

    localparam int OP_W    = 8 * OP_BYTES;
    localparam int N_BYTES = 3 * OP_BYTES + GP_BYTES;
    localparam int IDX_W   = $clog2(N_BYTES);

    sel_e             sel;
    state_e           st_w;
    logic [IDX_W-1:0] idx_w;
    logic [7:0]       rd_byte;
    logic [OP_W-1:0]  op_a_w, op_b_w, op_c_w, prod_w, quo_w, rem_w;
    logic mul_start, div_start, mul_done, div_done, lock, ld_ab, ld_c;
    logic mac_active, div_active, mac_acc, mac_wide, mac_sgn, div_rnd, div_sgn;

    assign sel = sel_e'(bus_sel);

    xmu_regfile #(.OP_BYTES(OP_BYTES), .GP_BYTES(GP_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .idx_wr(bus_wr && sel == SEL_INDEX), .idx_wdata(bus_wdata[IDX_W-1:0]),
        .acc_wr(bus_wr && sel == SEL_DATA), .acc_rd(bus_rd && sel == SEL_DATA),
        .acc_wdata(bus_wdata), .lock(lock), .ld_ab(ld_ab), .ld_c(ld_c),
        .res_a(quo_w), .res_b(rem_w), .res_c(prod_w),
        .rd_byte(rd_byte), .idx(idx_w), .op_a(op_a_w), .op_b(op_b_w), .op_c(op_c_w)
    );

    xmu_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_mac(bus_wr && sel == SEL_MACCTL), .wr_div(bus_wr && sel == SEL_DIVCTL),
        .go(bus_wdata[BIT_GO]), .mode(bus_wdata[BIT_MODE]),
        .wide(bus_wdata[BIT_WIDE]), .sgn(bus_wdata[BIT_SGN]),
        .mul_done(mul_done), .div_done(div_done),
        .mul_start(mul_start), .div_start(div_start), .lock(lock),
        .ld_ab(ld_ab), .ld_c(ld_c), .mac_active(mac_active), .div_active(div_active),
        .mac_acc(mac_acc), .mac_wide(mac_wide), .mac_sgn(mac_sgn),
        .div_rnd(div_rnd), .div_sgn(div_sgn), .st(st_w)
    );

    xmu_mul #(.OP_W(OP_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .start(mul_start),
        .wide(bus_wdata[BIT_WIDE]), .sgn(bus_wdata[BIT_SGN]), .acc(bus_wdata[BIT_MODE]),
        .a(op_a_w), .b(op_b_w), .c(op_c_w), .done(mul_done), .prod(prod_w)
    );

    xmu_div #(.OP_W(OP_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .sgn(bus_wdata[BIT_SGN]), .rnd(bus_wdata[BIT_MODE]),
        .dvd(op_c_w), .dvs(op_a_w), .done(div_done), .quo(quo_w), .rem(rem_w)
    );

    always_comb begin
        unique case (sel)
            SEL_INDEX:  bus_rdata = 8'(idx_w);
            SEL_DATA:   bus_rdata = rd_byte;
            SEL_MACCTL: bus_rdata = {mac_active, mac_acc, 1'b0, mac_wide, mac_sgn, 3'b000};
            SEL_DIVCTL: bus_rdata = {div_active, div_rnd, 2'b00, div_sgn, 3'b000};
        endcase
    end
endmodule

// File: rtl/xmu_chk.sv
module xmu_chk
    import xmu_pkg::*;
#(
    parameter  int OP_BYTES = 8,
    parameter  int GP_BYTES = 40,
    localparam int OP_W     = 8 * OP_BYTES,
    localparam int N_BYTES  = 3 * OP_BYTES + GP_BYTES,
    localparam int IDX_W    = $clog2(N_BYTES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_sel,
    input logic             go_bit,
    input state_e           st,
    input logic [IDX_W-1:0] idx,
    input logic [OP_W-1:0]  op_a,
    input logic [OP_W-1:0]  op_b,
    input logic [OP_W-1:0]  op_c,
    input logic             mac_active
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BYTES - 1);

    // R2
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_sel == 2'd1 && idx == LAST) |=> (idx == '0));

    // R9
    mac_go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && bus_wr && bus_sel == 2'd2 && go_bit) |=> mac_active);

    // R14
    run_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MUL_RUN || st == ST_DIV_RUN) |=> $stable({op_a, op_b, op_c}));

    // R8
    mac_keeps_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE_BACK && mac_active) |=> ($stable(op_a) && $stable(op_b)));

    // R13
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && bus_wr && bus_sel == 2'd3 && go_bit && op_a == '0)
        |=> ##2 (op_a == '1 && op_b == $past(op_c, 3)));
endmodule

bind xmath_unit xmu_chk #(.OP_BYTES(OP_BYTES), .GP_BYTES(GP_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .go_bit(bus_wdata[7]), .st(st_w), .idx(idx_w),
    .op_a(op_a_w), .op_b(op_b_w), .op_c(op_c_w), .mac_active(mac_active)
);

// File: tb/tb_xmath_unit.sv
module tb_xmath_unit;
    localparam logic [1:0] S_IDX = 2'd0, S_DAT = 2'd1, S_MAC = 2'd2, S_DIV = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    int errors = 0, checks = 0;

    xmath_unit dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
                    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    always #5 clk = ~clk;

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_sel = s; bus_wdata = d;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_sel = s;
        #1 d = bus_rdata;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic put64(input logic [7:0] base, input logic [63:0] v);
        wr(S_IDX, base);
        for (int i = 0; i < 8; i++) wr(S_DAT, v[63-8*i -: 8]);
        idle();
    endtask

    task automatic get64(input logic [7:0] base, output logic [63:0] v);
        logic [7:0] b;
        wr(S_IDX, base);
        for (int i = 0; i < 8; i++) begin
            rd(S_DAT, b);
            v[63-8*i -: 8] = b;
        end
        idle();
    endtask

    task automatic run_op(input logic [1:0] s, input logic [7:0] ctl,
                          output logic [7:0] first, output logic [7:0] last);
        logic [7:0] v;
        int n = 0;
        wr(s, ctl);
        rd(s, first);
        v = first;
        while (v[7] && n < 300) begin
            rd(s, v);
            n++;
        end
        last = v;
        idle();
    endtask

    task automatic load3(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
        put64(8'h00, a); put64(8'h08, b); put64(8'h10, c);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(S_IDX, v); chk(v == 8'h00, "R1 index", 64'(v), 64'h0);
        rd(S_MAC, v); chk(v == 8'h00, "R1 mac ctl", 64'(v), 64'h0);
        rd(S_DIV, v); chk(v == 8'h00, "R1 div ctl", 64'(v), 64'h0);
        rd(S_DAT, v); chk(v == 8'h00, "R1 byte 0", 64'(v), 64'h0);
        idle();
    endtask

    task automatic t_index();
        logic [7:0] v;
        int bad = 0;
        wr(S_IDX, 8'h3E); wr(S_DAT, 8'hA1); wr(S_DAT, 8'hA2);
        rd(S_IDX, v); chk(v == 8'h00, "R2 wrap after write", 64'(v), 64'h0);
        wr(S_IDX, 8'h3F); rd(S_DAT, v); chk(v == 8'hA2, "R2 byte 0x3F", 64'(v), 64'hA2);
        rd(S_IDX, v); chk(v == 8'h00, "R2 wrap after read", 64'(v), 64'h0);
        wr(S_IDX, 8'h18);
        for (int i = 0; i < 40; i++) wr(S_DAT, 8'(i * 3 + 1));
        wr(S_IDX, 8'h18);
        for (int i = 0; i < 40; i++) begin
            rd(S_DAT, v);
            if (v != 8'(i * 3 + 1)) bad++;
        end
        idle();
        chk(bad == 0, "R4 scratch bytes mismatches", 64'(bad), 64'h0);
    endtask

    task automatic t_mac32();
        logic [7:0] f, l;
        logic [63:0] r;
        load3(64'hDEADBEEF_00001234, 64'hCAFEF00D_00005678, 64'hFFFFFFFF_FFFFE000);
        run_op(S_MAC, 8'hC8, f, l);
        chk(f[7] == 1'b1, "R9 mac busy", 64'(f), 64'hC8);
        chk(l == 8'h48, "R9 mac cleared", 64'(l), 64'h48);
        get64(8'h10, r); chk(r == 64'h000000000625E060, "R5 signed 32 mac", r, 64'h000000000625E060);
        get64(8'h00, r); chk(r == 64'hDEADBEEF_00001234, "R8 A kept R3", r, 64'hDEADBEEF_00001234);
        load3(64'h12345678_FFFFFFFD, 64'h00000000_00000005, 64'h55555555_55555555);
        run_op(S_MAC, 8'h88, f, l);
        get64(8'h10, r); chk(r == 64'hFFFFFFFF_FFFFFFF1, "R5 R8 signed 32 mul", r, 64'hFFFFFFFF_FFFFFFF1);
        load3(64'h0000FFFF_FFFFFFFF, 64'hFFFF0000_00000002, 64'h0);
        run_op(S_MAC, 8'h80, f, l);
        get64(8'h10, r); chk(r == 64'h00000001_FFFFFFFE, "R6 unsigned 32 mul", r, 64'h00000001_FFFFFFFE);
    endtask

    task automatic t_mac64();
        logic [7:0] f, l;
        logic [63:0] r, a, b, c, e;
        a = 64'h00000100_00000003; b = 64'h0000FFFF_40000001; c = 64'h0123_4567_89AB_CDEF;
        load3(a, b, c);
        run_op(S_MAC, 8'h90, f, l);
        e = a * b;
        get64(8'h10, r); chk(r == e, "R7 64 mul truncated", r, e);
        load3(a, b, c);
        run_op(S_MAC, 8'hD0, f, l);
        e = a * b + c;
        get64(8'h10, r); chk(r == e, "R7 64 mac", r, e);
        load3(64'hFFFFFFFF_FFFFFFF9, 64'd9, 64'd0);
        run_op(S_MAC, 8'h98, f, l);
        get64(8'h10, r); chk(r == 64'hFFFFFFFF_FFFFFFC1, "R7 signed 64", r, 64'hFFFFFFFF_FFFFFFC1);
        get64(8'h08, r); chk(r == 64'd9, "R8 B kept", r, 64'd9);
    endtask

    task automatic div_case(input string tag, input logic [7:0] ctl, input logic [63:0] cv,
                            input logic [63:0] av, input logic [63:0] eq, input logic [63:0] er);
        logic [7:0] f, l;
        logic [63:0] r;
        load3(av, 64'h0, cv);
        run_op(S_DIV, ctl, f, l);
        get64(8'h00, r); chk(r == eq, {tag, " quotient"}, r, eq);
        get64(8'h08, r); chk(r == er, {tag, " remainder"}, r, er);
        get64(8'h10, r); chk(r == cv, {tag, " C kept"}, r, cv);
    endtask

    task automatic t_div();
        logic [7:0] f, l;
        div_case("R10 unsigned", 8'h80, 64'd1000003, 64'd1000, 64'd1000, 64'd3);
        div_case("R11 neg dividend", 8'h88, -64'sd100, 64'd7, -64'sd14, -64'sd2);
        div_case("R11 neg divisor", 8'h88, 64'd100, -64'sd7, -64'sd14, 64'd2);
        div_case("R12 unsigned tie", 8'hC0, 64'd7, 64'd2, 64'd4, 64'hFFFFFFFF_FFFFFFFF);
        div_case("R12 signed tie", 8'hC8, -64'sd7, 64'd2, -64'sd4, 64'd1);
        div_case("R12 no round", 8'hC8, 64'd9, 64'd4, 64'd2, 64'd1);
        div_case("R13 zero divisor", 8'h88, 64'h12345678_9ABCDEF0, 64'd0,
                 64'hFFFFFFFF_FFFFFFFF, 64'h12345678_9ABCDEF0);
        put64(8'h00, 64'd5);
        run_op(S_DIV, 8'hC8, f, l);
        chk(f[7] == 1'b1, "R9 div busy", 64'(f), 64'hC8);
        chk(l == 8'h48, "R9 div cleared", 64'(l), 64'h48);
    endtask

    task automatic t_lock();
        logic [7:0] f, l;
        logic [63:0] r;
        // B = 0: busy for exactly the run cycle and the write-back cycle
        load3(64'h11111111_11111111, 64'h0, 64'h77);
        wr(S_IDX, 8'h05);
        wr(S_MAC, 8'h80);
        wr(S_DAT, 8'hA5);
        wr(S_DAT, 8'hA6);
        wr(S_DAT, 8'hA7);
        idle();
        get64(8'h00, r); chk(r == 64'h11111111_111111A7, "R14 write-back edge", r, 64'h11111111_111111A7);
        get64(8'h10, r); chk(r == 64'h0, "R14 result kept", r, 64'h0);
        load3(64'd1, 64'hFFFF, 64'h0);
        wr(S_MAC, 8'h80);
        wr(S_IDX, 8'h16);
        wr(S_DAT, 8'hEE);
        wr(S_DAT, 8'hEE);
        run_op(S_MAC, 8'h00, f, l);
        get64(8'h10, r); chk(r == 64'hFFFF, "R14 writes during run", r, 64'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_mac32();
        t_mac64();
        t_div();
        t_lock();
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule